// File: doc/BRIEF.md
# Receive Signal-Detect Qualifier

This block turns a stream of peak-to-peak amplitude readings from the receive equalizer into a single signal-detect flag. Each reading is an unsigned millivolt code that arrives with a valid strobe. The flag uses hysteresis. It is set only after the amplitude has stayed at or above the high threshold for a set number of clock cycles. It is cleared only after the amplitude has stayed below the low threshold for a shorter set number of cycles. Readings between the two thresholds leave the flag as it is.

Two override inputs sit above the hysteresis path, in a fixed priority. Loopback forces the flag high, even when a cable fault is also present. A cable fault, when loopback is off, forces the flag low. While either override is active, the hysteresis state is frozen and both persistence counters are held at zero. When the override is released, the flag returns to the frozen state and any persistence run starts again from zero.

The default persistence windows are 40 µs to set the flag and 12 µs to clear it, at a 50 MHz clock. Both values sit inside the required turn-on and turn-off limits.

Top module: `sdq_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `sigdet_o` is 0 and both persistence counts are zero.
- R2: A reading counts as high only if `amp_mv_i >= ON_MV` (700 by default). A reading of `ON_MV-1` never sets the flag, however long it is held.
- R3: A reading counts as low only if `amp_mv_i < OFF_MV` (200 by default). A reading equal to `OFF_MV` never clears the flag.
- R4: A reading in the range `OFF_MV <= amp < ON_MV` holds the hysteresis state and resets any persistence run in progress.
- R5: With the flag low and no override, `sigdet_o` rises at the clock edge of the `ON_CYC`-th consecutive cycle whose class is high. It does not rise at an earlier edge.
- R6: With the flag high and no override, `sigdet_o` falls at the clock edge of the `OFF_CYC`-th consecutive cycle whose class is low.
- R7: A single cycle whose class breaks the condition restarts the persistence run from zero.
- R8: In a cycle where `sample_vld_i` is 0, `amp_mv_i` is ignored and the class of the last valid reading applies. Before the first valid reading, the class is low.
- R9: With `cable_fault_i`=1 and `loopback_i`=0, `sigdet_o` is 0 after the next edge.
- R10: With `loopback_i`=1, `sigdet_o` is 1 after the next edge, whatever the values of `cable_fault_i` and the amplitude.
- R11: While either override is 1, both persistence counts are zero and the hysteresis state does not change. Once the overrides are released, `sigdet_o` follows that state again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_vld_i | input | 1 | Marks `amp_mv_i` as a new reading |
| amp_mv_i | input | AMP_W | Peak-to-peak amplitude in mV, unsigned |
| loopback_i | input | 1 | Loopback override; forces the flag high |
| cable_fault_i | input | 1 | Cable fault override; forces the flag low |
| sigdet_o | output | 1 | Registered signal-detect flag |

## Verification
The bench builds the block with `ON_CYC`=8 and `OFF_CYC`=3 and keeps the default 700/200 mV thresholds. These short windows make every set and clear edge, every restart caused by a break, and every override release reachable within a few cycles. They also let a random sweep that crosses both thresholds complete hundreds of flag transitions. The asymmetry between the two windows is kept, so a mix-up between the set and clear counts shows up at the ports.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  typedef enum logic [1:0] {
    AMP_LO  = 2'd0,
    AMP_MID = 2'd1,
    AMP_HI  = 2'd2
  } amp_cls_e;
endpackage

// File: rtl/sdq_classify.sv
module sdq_classify
  import sdq_pkg::*;
#(
  parameter int AMP_W  = 12,
  parameter int ON_MV  = 700,
  parameter int OFF_MV = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [AMP_W-1:0] amp_i,
  output amp_cls_e         cls_o
);
  localparam logic [AMP_W-1:0] OnThr  = AMP_W'(ON_MV);
  localparam logic [AMP_W-1:0] OffThr = AMP_W'(OFF_MV);

  amp_cls_e last_q, smp_cls;

  always_comb begin
    if (amp_i >= OnThr)     smp_cls = AMP_HI;
    else if (amp_i < OffThr) smp_cls = AMP_LO;
    else                     smp_cls = AMP_MID;
  end

  assign cls_o = vld_i ? smp_cls : last_q;

  // hold class of last valid reading between strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= AMP_LO;
    else         last_q <= cls_o;
  end
endmodule

// File: rtl/sdq_persist.sv
module sdq_persist #(
  parameter int LIMIT = 8,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  output logic          fire_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  assign fire_o = run_i && (cnt_q == CW'(LIMIT - 1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (fire_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sdq_top.sv
module sdq_top
  import sdq_pkg::*;
#(
  parameter int AMP_W   = 12,
  parameter int ON_MV   = 700,
  parameter int OFF_MV  = 200,
  parameter int CLK_MHZ = 50,
  parameter int ON_US   = 40,
  parameter int OFF_US  = 12,
  parameter int ON_CYC  = ON_US * CLK_MHZ,
  parameter int OFF_CYC = OFF_US * CLK_MHZ
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_vld_i,
  input  logic [AMP_W-1:0] amp_mv_i,
  input  logic             loopback_i,
  input  logic             cable_fault_i,
  output logic             sigdet_o
);
  localparam int ON_W  = $clog2(ON_CYC + 1);
  localparam int OFF_W = $clog2(OFF_CYC + 1);

  amp_cls_e         cur_cls;
  logic             hyst_q, hyst_d, ovr;
  logic             on_run, off_run, on_fire, off_fire;
  logic [ON_W-1:0]  on_cnt;
  logic [OFF_W-1:0] off_cnt;
  logic             sigdet_q;

  sdq_classify #(.AMP_W(AMP_W), .ON_MV(ON_MV), .OFF_MV(OFF_MV)) u_cls (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (sample_vld_i),
    .amp_i (amp_mv_i),
    .cls_o (cur_cls)
  );

  assign ovr     = loopback_i | cable_fault_i;
  assign on_run  = !ovr && !hyst_q && (cur_cls == AMP_HI);
  assign off_run = !ovr &&  hyst_q && (cur_cls == AMP_LO);

  sdq_persist #(.LIMIT(ON_CYC)) u_on (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (on_run),
    .fire_o(on_fire),
    .cnt_o (on_cnt)
  );

  sdq_persist #(.LIMIT(OFF_CYC)) u_off (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (off_run),
    .fire_o(off_fire),
    .cnt_o (off_cnt)
  );

  assign hyst_d = hyst_q ? !off_fire : on_fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hyst_q   <= 1'b0;
      sigdet_q <= 1'b0;
    end else begin
      hyst_q   <= hyst_d;
      // loopback outranks cable fault
      sigdet_q <= loopback_i | (!cable_fault_i & hyst_d);
    end
  end

  assign sigdet_o = sigdet_q;
endmodule

// File: rtl/sdq_top_chk.sv
module sdq_top_chk
  import sdq_pkg::*;
#(
  parameter int ON_CYC  = 8,
  parameter int OFF_CYC = 3,
  localparam int ON_W   = $clog2(ON_CYC + 1),
  localparam int OFF_W  = $clog2(OFF_CYC + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             loopback_i,
  input logic             cable_fault_i,
  input logic             sigdet_o,
  input amp_cls_e         cur_cls,
  input logic             hyst_q,
  input logic [ON_W-1:0]  on_cnt,
  input logic [OFF_W-1:0] off_cnt
);
  logic             ovr;
  logic [ON_W-1:0]  hi_run;
  logic [OFF_W-1:0] lo_run;

  assign ovr = loopback_i | cable_fault_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      if (!ovr && !hyst_q && cur_cls == AMP_HI)
        hi_run <= (hi_run == ON_W'(ON_CYC)) ? hi_run : hi_run + 1'b1;
      else
        hi_run <= '0;
      if (!ovr && hyst_q && cur_cls == AMP_LO)
        lo_run <= (lo_run == OFF_W'(OFF_CYC)) ? lo_run : lo_run + 1'b1;
      else
        lo_run <= '0;
    end
  end

  assert_no_rise_without_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hyst_q && cur_cls != AMP_HI) |=> !hyst_q);
  assert_no_fall_without_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hyst_q && cur_cls != AMP_LO) |=> hyst_q);
  assert_mid_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_cls == AMP_MID) |=> $stable(hyst_q));
  assert_rise_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hyst_q) |-> ($past(hi_run) == ON_W'(ON_CYC - 1)));
  assert_fall_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hyst_q) |-> ($past(lo_run) == OFF_W'(OFF_CYC - 1)));
  assert_fault_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cable_fault_i && !loopback_i) |=> !sigdet_o);
  assert_loop_on_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loopback_i |=> sigdet_o);
  assert_ovr_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr |=> (on_cnt == '0 && off_cnt == '0 && $stable(hyst_q)));
endmodule

bind sdq_top sdq_top_chk #(.ON_CYC(ON_CYC), .OFF_CYC(OFF_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .loopback_i   (loopback_i),
  .cable_fault_i(cable_fault_i),
  .sigdet_o     (sigdet_o),
  .cur_cls      (cur_cls),
  .hyst_q       (hyst_q),
  .on_cnt       (on_cnt),
  .off_cnt      (off_cnt)
);

// File: tb/sdq_top_tb_top.sv
module sdq_top_tb_top;
  localparam int AMP_W = 12;
  localparam int ON_MV = 700;
  localparam int OFF_MV = 200;
  localparam int ON_CYC = 8;
  localparam int OFF_CYC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [AMP_W-1:0] amp = '0;
  logic lb = 1'b0;
  logic cf = 1'b0;
  logic sd;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // reference state
  int m_last, m_cnt;
  bit m_hyst, m_out;

  always #10 clk = ~clk;

  sdq_top #(.AMP_W(AMP_W), .ON_MV(ON_MV), .OFF_MV(OFF_MV),
            .ON_CYC(ON_CYC), .OFF_CYC(OFF_CYC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_vld_i(vld), .amp_mv_i(amp),
    .loopback_i(lb), .cable_fault_i(cf), .sigdet_o(sd)
  );

  // 0 low, 1 mid, 2 high
  function automatic int cls_of(int a);
    if (a >= ON_MV) return 2;
    if (a < OFF_MV) return 0;
    return 1;
  endfunction

  task automatic chk(string tag, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: sigdet_o=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int cur;
    cur = vld ? cls_of(int'(amp)) : m_last;
    if (lb || cf) m_cnt = 0;
    else if (!m_hyst && cur == 2) begin
      if (m_cnt == ON_CYC - 1) begin m_hyst = 1; m_cnt = 0; end
      else m_cnt++;
    end else if (m_hyst && cur == 0) begin
      if (m_cnt == OFF_CYC - 1) begin m_hyst = 0; m_cnt = 0; end
      else m_cnt++;
    end else m_cnt = 0;
    m_out = lb | (!cf & m_hyst);
    m_last = cur;
  endtask

  task automatic step(bit v, int a, bit l, bit c, string tag);
    @(negedge clk);
    vld = v; amp = AMP_W'(a); lb = l; cf = c;
    model_step();
    @(posedge clk);
    #1;
    chk(tag, sd, m_out);
  endtask

  task automatic run(int n, int a, string tag);
    for (int i = 0; i < n; i++) step(1'b1, a, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run hung");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    m_last = 0; m_cnt = 0; m_hyst = 0; m_out = 0;
    repeat (3) @(posedge clk);
    #1 chk("R1 in reset", sd, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 chk("R1 after reset", sd, 1'b0);

    run(3, 0, "R1 idle");
    run(7, 700, "R5 count");
    chk("R5 not before ON_CYC", sd, 1'b0);
    run(1, 700, "R5 edge");
    chk("R5 R2 set at 700", sd, 1'b1);
    run(2, 199, "R6 count");
    chk("R6 not before OFF_CYC", sd, 1'b1);
    run(1, 199, "R6 edge");
    chk("R6 R3 cleared at 199", sd, 1'b0);
    run(20, 699, "R2 boundary");
    chk("R2 699 never sets", sd, 1'b0);
    run(5, 700, "R7 run");
    run(1, 450, "R7 break");
    run(7, 700, "R7 restart");
    chk("R7 count restarted", sd, 1'b0);
    run(1, 700, "R7 edge");
    chk("R7 set after full run", sd, 1'b1);
    run(20, 200, "R3 boundary");
    chk("R3 200 never clears", sd, 1'b1);
    run(10, 450, "R4 mid");
    chk("R4 mid holds high", sd, 1'b1);
    step(1'b1, 100, 1'b0, 1'b0, "R8 sample");
    step(1'b0, 900, 1'b0, 1'b0, "R8 held");
    step(1'b0, 900, 1'b0, 1'b0, "R8 held");
    chk("R8 held low class clears", sd, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 900, 1'b0, 1'b0, "R8 ignored");
    chk("R8 amp ignored without strobe", sd, 1'b0);
    run(8, 800, "R9 setup");
    step(1'b1, 800, 1'b0, 1'b1, "R9 fault");
    chk("R9 fault forces low", sd, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b1, 0, 1'b0, 1'b1, "R11 frozen");
    step(1'b1, 450, 1'b0, 1'b0, "R11 release");
    chk("R11 returns to held high", sd, 1'b1);
    step(1'b1, 0, 1'b1, 1'b1, "R10 priority");
    chk("R10 loopback over fault", sd, 1'b1);
    run(3, 0, "R11 clear low");
    chk("R6 cleared", sd, 1'b0);
    run(6, 700, "R11 partial");
    step(1'b1, 700, 1'b0, 1'b1, "R11 clears count");
    run(7, 700, "R11 restart");
    chk("R11 count cleared by override", sd, 1'b0);
    run(1, 700, "R11 edge");
    chk("R11 set after fresh run", sd, 1'b1);

    for (int s = 0; s < 600; s++) begin
      int len, a, sel;
      bit l, c;
      len = 1 + int'($urandom_range(11));
      sel = int'($urandom_range(5));
      case (sel)
        0: a = int'($urandom_range(OFF_MV - 1));
        1: a = OFF_MV - 1 + int'($urandom_range(2));
        2: a = OFF_MV + int'($urandom_range(ON_MV - OFF_MV - 1));
        3: a = ON_MV - 1 + int'($urandom_range(2));
        default: a = ON_MV + int'($urandom_range(2000));
      endcase
      l = ($urandom_range(19) == 0);
      c = ($urandom_range(9) == 0);
      for (int i = 0; i < len; i++)
        step(($urandom_range(3) != 0), a, l, c, "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule